// File: doc/BRIEF.md
# Watchdog Safe-Frequency Fallback Controller

This block watches over the frequency-select path of a clock generator. Software arms it with an enable bit and a timeout expressed in units of 290 ms. A prescaler turns an incoming 1 ms tick into those units. While the watchdog is armed, every service strobe restarts the countdown. If the timeout passes with no service, the block latches an alarm status. It then replaces the normal 5-bit frequency code with a stored safe code and drives an active-low system reset pulse.

The same reset pulse also fires on its own whenever the effective frequency code changes. This covers a change in the normal selection, the switch to the safe code, and the return from it. The pulse lasts a fixed, parameterised number of ticks, and a new trigger restarts it. The alarm and the override stay in force until software clears the status bit or drops the enable. The PLL and the register file sit outside this block. Their fields arrive here as plain inputs.

Top module: `wdt_safe_sel`

## Requirements
- R1: After reset, `alarm` is 0, `sys_rst_n` is 1 and `eff_sel` equals `norm_sel`.
- R2: While `wd_en` is 0, no amount of elapsed ticks raises `alarm`, and `eff_sel` follows `norm_sel`.
- R3: Arming loads the timer. Arming means `wd_en` rising, or a service strobe while armed. With `wd_units` = N ≥ 1, `alarm` rises at the clock edge of the (N·290)-th tick after the loading edge. With `tick_ms` high every cycle, that is exactly N·290 edges after the load.
- R4: With `wd_units` = 0, the timeout comes at the first unit boundary after arming, which is 290 ticks.
- R5: A `service` pulse while armed restarts the full timeout from the edge that samples it.
- R6: While `alarm` is 1, `eff_sel` equals `safe_code`. Bit 4 of both codes is the extra select bit beyond the four strap bits, and bits 3:0 are those four strap bits in order.
- R7: `alarm` stays 1 until `alarm_clr` or `wd_en`=0 is sampled. It is 0 after that edge, and `eff_sel` returns to `norm_sel`. Clearing with `wd_en` still 1 re-arms the watchdog on the next edge.
- R8: A change of `eff_sel` drives `sys_rst_n` low from the next edge on, for exactly RST_TICKS ticks.
- R9: A timeout drives `sys_rst_n` low at the expiry edge, even when the safe code equals the normal code.
- R10: A new trigger during a reset pulse restarts the full RST_TICKS hold.
- R11: The timeout advances only on cycles with `tick_ms` high. With no ticks, the watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms time strobe |
| wd_en | input | 1 | Watchdog enable field |
| wd_units | input | 8 | Timeout in 290 ms units |
| safe_code | input | 5 | Fallback frequency code |
| norm_sel | input | 5 | Normal frequency code |
| service | input | 1 | Service strobe that restarts the countdown |
| alarm_clr | input | 1 | Software clear of the alarm status |
| eff_sel | output | 5 | Effective frequency code |
| alarm | output | 1 | Alarm status (1 = watchdog expired) |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The embedded properties watch several rules on every cycle:
- the alarm can only rise right after an expiry event;
- a disabled watchdog never expires and never holds an alarm;
- an armed alarm persists until it is cleared;
- every expiry and every trigger pulls the reset low on the next edge;
- the time counters freeze when no tick arrives.

Only the bench scenarios can show the exact expiry edge for several unit counts, including the zero-count case. The same holds for the restart caused by service, the exact pulse length, the stretch on retrigger, and the substituted safe code value.

// File: rtl/wdt_fallback_pkg.sv
package wdt_fallback_pkg;

  // Number of ticks before expiry for a programmed unit count.
  function automatic int unsigned expiry_ticks(input int unsigned units,
                                               input int unsigned per_unit);
    return ((units == 0) ? 1 : units) * per_unit;
  endfunction

  // Effective code selection: the safe code overrides while in alarm.
  function automatic logic [4:0] pick_sel(input logic in_alarm,
                                          input logic [4:0] safe,
                                          input logic [4:0] norm);
    return in_alarm ? safe : norm;
  endfunction

endpackage

// File: rtl/wdt_unit_prescaler.sv
module wdt_unit_prescaler #(
  parameter int TICKS_PER_UNIT = 290
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic unit_pulse
);
  localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

  logic [PW-1:0] pre;
  logic          at_last;

  assign at_last    = (pre == LAST);
  assign unit_pulse = run & ~restart & tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (!run || restart)  pre <= '0;
    else if (tick)             pre <= at_last ? '0 : pre + PW'(1);
  end

  // R11: without a tick the sub-unit count does not move
  p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> $stable(pre));

endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             unit_pulse,
  input  logic [CNT_W-1:0] units,
  output logic             expired
);
  logic [CNT_W-1:0] remaining;
  logic             last_unit;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign last_unit = (remaining <= CNT_W'(1));
  assign expired   = unit_pulse & ~restart & last_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       remaining <= '0;
    else if (restart)                 remaining <= units;
    else if (unit_pulse && !last_unit) remaining <= step_down(remaining);
  end

  // R3: the unit count only moves on a unit boundary
  p_count_only_on_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !unit_pulse) |=> $stable(remaining));

endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
  parameter int HOLD_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic tick,
  output logic rst_out_n
);
  localparam int RW = $clog2(HOLD_TICKS + 1);

  logic [RW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hold <= '0;
    else if (trigger)               hold <= RW'(HOLD_TICKS);
    else if (tick && hold != '0)    hold <= hold - RW'(1);
  end

  assign rst_out_n = (hold == '0);

  // R8: any trigger pulls the reset low on the next edge
  p_trigger_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !rst_out_n);

  // R8: release only happens after a tick was counted
  p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick));

endmodule

// File: rtl/wdt_safe_sel.sv
module wdt_safe_sel
  import wdt_fallback_pkg::*;
#(
  parameter int SEL_W          = 5,
  parameter int CNT_W          = 8,
  parameter int TICKS_PER_UNIT = 290,
  parameter int RST_TICKS      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             wd_en,
  input  logic [CNT_W-1:0] wd_units,
  input  logic [SEL_W-1:0] safe_code,
  input  logic [SEL_W-1:0] norm_sel,
  input  logic             service,
  input  logic             alarm_clr,
  output logic [SEL_W-1:0] eff_sel,
  output logic             alarm,
  output logic             sys_rst_n
);
  logic             run, run_q, restart;
  logic             unit_pulse, expired;
  logic [SEL_W-1:0] eff_q;
  logic             primed, sel_change, rst_trig;

  assign run     = wd_en & ~alarm;
  assign restart = run & (~run_q | service);

  wdt_unit_prescaler #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .tick(tick_ms), .unit_pulse(unit_pulse));

  wdt_unit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .unit_pulse(unit_pulse), .units(wd_units), .expired(expired));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      alarm  <= 1'b0;
      eff_q  <= '0;
      primed <= 1'b0;
    end else begin
      run_q  <= run;
      eff_q  <= eff_sel;
      primed <= 1'b1;
      if (!wd_en || alarm_clr) alarm <= 1'b0;
      else if (expired)        alarm <= 1'b1;
    end
  end

  generate
    if (SEL_W == 5) begin : g_pkg_sel
      assign eff_sel = pick_sel(alarm, safe_code, norm_sel);
    end else begin : g_wide_sel
      assign eff_sel = alarm ? safe_code : norm_sel;
    end
  endgenerate

  assign sel_change = primed & (eff_sel != eff_q);
  assign rst_trig   = sel_change | expired;

  wdt_reset_stretch #(.HOLD_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .trigger(rst_trig), .tick(tick_ms),
    .rst_out_n(sys_rst_n));

  // R3: alarm can only rise after an expiry event
  p_alarm_from_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(expired));

  // R2: a disabled watchdog never expires
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !expired);

  // R7: disable clears the alarm
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !alarm);

  // R7: alarm persists while armed and not cleared
  p_alarm_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && wd_en && !alarm_clr) |=> alarm);

  // R9: expiry drives the system reset low on the next edge
  p_expiry_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !sys_rst_n);

endmodule

// File: tb/sim_wdt_safe_sel.sv
module sim_wdt_safe_sel;
  localparam int TPU = 290;
  localparam int RST = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b1;
  logic       wd_en = 1'b0;
  logic [7:0] wd_units = 8'd16;
  logic [4:0] safe_code = 5'h00;
  logic [4:0] norm_sel = 5'h0B;
  logic       service = 1'b0;
  logic       alarm_clr = 1'b0;
  logic [4:0] eff_sel;
  logic       alarm;
  logic       sys_rst_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_safe_sel u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wd_en(wd_en),
    .wd_units(wd_units), .safe_code(safe_code), .norm_sel(norm_sel),
    .service(service), .alarm_clr(alarm_clr), .eff_sel(eff_sel),
    .alarm(alarm), .sys_rst_n(sys_rst_n));

  // units[17:10], normal code[9:5], safe code[4:0]
  localparam logic [17:0] VEC [0:3] = '{
    {8'd1, 5'h03, 5'h1C},
    {8'd2, 5'h11, 5'h00},
    {8'd0, 5'h0A, 5'h15},
    {8'd3, 5'h07, 5'h07}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wait_for(input int units);
    int t;
    t = TPU;
    if (units > 1) t = TPU * units;
    return t;
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 alarm", alarm, 0);
    chk("R1 sys_rst_n", sys_rst_n, 1);
    chk("R1 eff_sel", eff_sel, norm_sel);

    // R2: disabled for many units
    wd_units = 8'd1;
    step(700);
    chk("R2 alarm", alarm, 0);
    chk("R2 eff_sel", eff_sel, 5'h0B);

    // table of timeout scenarios (R3, R4, R6, R7, R9)
    for (int i = 0; i < 4; i++) begin
      int t;
      string rq;
      wd_units  = VEC[i][17:10];
      norm_sel  = VEC[i][9:5];
      safe_code = VEC[i][4:0];
      rq = (VEC[i][17:10] == 0) ? "R4" : "R3";
      t = wait_for(int'(VEC[i][17:10]));
      step(RST + 4);
      wd_en = 1'b1;
      step(t);
      chk({rq, " before expiry"}, alarm, 0);
      chk("R6 code before expiry", eff_sel, VEC[i][9:5]);
      step(1);
      chk({rq, " at expiry"}, alarm, 1);
      chk("R9 reset at expiry", sys_rst_n, 0);
      chk("R6 safe code", eff_sel, VEC[i][4:0]);
      step(30);
      chk("R7 alarm held", alarm, 1);
      wd_en = 1'b0;
      step(1);
      chk("R7 cleared by disable", alarm, 0);
      chk("R7 code restored", eff_sel, VEC[i][9:5]);
      step(RST + 4);
    end

    // R11: no ticks, no expiry
    wd_units = 8'd1;
    tick_ms = 1'b0;
    wd_en = 1'b1;
    step(1000);
    chk("R11 frozen", alarm, 0);
    tick_ms = 1'b1;
    step(289);
    chk("R11 before expiry", alarm, 0);
    step(1);
    chk("R11 expiry", alarm, 1);
    wd_en = 1'b0;
    step(RST + 4);

    // R5: service restarts the countdown
    wd_en = 1'b1;
    step(200);
    service = 1'b1;
    step(1);
    service = 1'b0;
    step(289);
    chk("R5 no early expiry", alarm, 0);
    step(1);
    chk("R5 expiry after service", alarm, 1);
    wd_en = 1'b0;
    step(RST + 4);

    // R7: software clear and re-arm
    wd_units = 8'd2;
    wd_en = 1'b1;
    step(581);
    chk("R7 expired", alarm, 1);
    alarm_clr = 1'b1;
    step(1);
    alarm_clr = 1'b0;
    chk("R7 cleared by clr", alarm, 0);
    chk("R7 code back", eff_sel, norm_sel);
    step(580);
    chk("R7 rearm pending", alarm, 0);
    step(1);
    chk("R7 rearm expiry", alarm, 1);
    wd_en = 1'b0;
    step(RST + 4);

    // R8: exact pulse on a code change
    norm_sel = 5'h12;
    step(1);
    chk("R8 low start", sys_rst_n, 0);
    step(RST - 1);
    chk("R8 low end", sys_rst_n, 0);
    step(1);
    chk("R8 released", sys_rst_n, 1);

    // R10: retrigger stretches the pulse
    norm_sel = 5'h04;
    step(3);
    norm_sel = 5'h05;
    step(RST);
    chk("R10 still low", sys_rst_n, 0);
    step(1);
    chk("R10 released", sys_rst_n, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule